// File: doc/BRIEF.md
# Modulated Phase-Accumulator NCO

This block is a numerically controlled oscillator for frequency and phase keying. On every clock it adds a frequency step to a wide phase register. The step is the sum of a center word, an offset word that can be switched off, and a low-order auxiliary word that can also be switched off. The upper bits of the phase, turned by a pin-selected number of quarter turns, address a sine table. The table stores only one quarter of the wave. Its 16-bit result is rounded to a 14-bit sample.

Switching the offset word on and off gives two-tone FSK with no reprogramming. The phase-select pins give four-phase PSK. A feedback control turns the accumulator into a plain register that holds the step value. This freezes the phase at a chosen point. The tuning words come from a register block outside this core, and the core only reads them.

Top module: `nco_mod_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the phase register and every pipeline stage are cleared. `sample` then reads the zero code: 0 in two's complement, 14'h2000 in the offset-binary variant.
- R2: With `fb_en` high, each clock adds `center_word + offset_word` to the 48-bit phase register while `offset_en` is high. Carries out of the low 38 bits reach the table address.
- R3: With `offset_en` low, the offset term is zero. Raising `offset_en` again restores the offset without the word being rewritten.
- R4: `phase_sel` value k (0 to 3) adds k quarter turns, that is k<<8, to the 10-bit table address taken from phase bits 47:38.
- R5: Let q = address bits 9:8, i = bits 7:0 and T[i] = round(32767*sin(pi*(2i+1)/1024)). The 16-bit amplitude is +T[i] for q=0, +T[255-i] for q=1, -T[i] for q=2 and -T[255-i] for q=3.
- R6: The 14-bit two's-complement sample is floor((a+2)/4), where a is the 16-bit amplitude. This rounds halves upward.
- R7: A rounded result above 8191 saturates to 8191. The most negative amplitude gives -8192 (14'h2000).
- R8: With `fb_en` low, the phase register loads only the current step, so the phase stays fixed. With `fb_en` high again, accumulation resumes.
- R9: With `serial_en` high, `serial_word`, zero-extended at the LSB end, is added to the step. With `serial_en` low it has no effect, and it counts again once re-enabled.
- R10: A change on `phase_sel` reaches `sample` on the third rising edge after it is applied.
- R11: A change on a tuning word, `offset_en`, `serial_en` or `fb_en` reaches `sample` on the fourth rising edge.
- R12: The phase register wraps modulo 2^48, so the table address wraps from 1023 to 0.
- R13: With `OUT_OFFSET_BIN` = 1, `sample` is the two's-complement code with its MSB inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| center_word | input | 48 | Center frequency step |
| offset_word | input | 48 | Offset frequency step |
| serial_word | input | 40 | Auxiliary low-order frequency step |
| offset_en | input | 1 | Adds the offset step when high |
| serial_en | input | 1 | Adds the auxiliary step when high |
| fb_en | input | 1 | Accumulates when high; loads the step alone when low |
| phase_sel | input | 2 | Quarter-turn phase offset count |
| sample | output | 14 | Rounded sine sample |

## Verification
The bench builds the core with its default 48-bit phase, a 10-bit table address and a 14-bit output. It also builds a second instance with the offset-binary output selected. Frequency words are placed at bit 38 and above, so one clock moves the table address by chosen steps. With this, a run of little more than a thousand clocks covers every table entry, both mirror quadrants and the wrap of the phase register. A vector with all ones in the low 38 bits checks that the carry from the hidden phase bits reaches the address.

// File: rtl/nco_pkg.sv
// nco_pkg: shared constants and an elaboration-time helper for the NCO.
// Assumes real arithmetic is available for constant evaluation only.
package nco_pkg;

    localparam real NCO_PI = 3.141592653589793;

    // Rounded quarter-wave amplitude for table entry idx of qdepth entries.
    function automatic int quarter_amp(input int idx, input int qdepth, input real full);
        real ang;
        ang = NCO_PI * real'(2 * idx + 1) / real'(4 * qdepth);
        return $rtoi(full * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
// nco_phase_acc: forms the per-clock phase step and updates the phase register.
// Assumes SER_W < ACC_W; the auxiliary word is zero-extended at the LSB end.
module nco_phase_acc #(
    parameter int ACC_W = 48,
    parameter int SER_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] center_word,
    input  logic [ACC_W-1:0] offset_word,
    input  logic [SER_W-1:0] serial_word,
    input  logic             offset_en,
    input  logic             serial_en,
    input  logic             fb_en,
    output logic [ACC_W-1:0] acc_q
);
    localparam int PAD_W = ACC_W - SER_W;

    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] base;

    // Gate the optional terms and sum the step.
    always_comb begin
        step = center_word
             + (offset_en ? offset_word : '0)
             + (serial_en ? {{PAD_W{1'b0}}, serial_word} : '0);
        base = fb_en ? acc_q : '0;
    end

    // Phase register: accumulate, or load the step when feedback is off.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= base + step;
    end
endmodule

// File: rtl/nco_phase_map.sv
// nco_phase_map: takes the top table-address bits of the phase and adds the
// quarter-turn offset. Registered stage. Assumes LUT_AW >= 3.
module nco_phase_map #(
    parameter int ACC_W  = 48,
    parameter int LUT_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  acc_q,
    input  logic [1:0]        phase_sel,
    output logic [LUT_AW-1:0] ph_addr
);
    localparam int LOW_W = ACC_W - LUT_AW;

    logic [LUT_AW-1:0] turn;
    logic              unused_low;

    // Build the quarter-turn addend and collect the bits below the address.
    always_comb begin
        turn       = {phase_sel, {(LUT_AW-2){1'b0}}};
        unused_low = ^acc_q[LOW_W-1:0];
    end

    // Register the rotated table address.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_addr <= '0;
        else        ph_addr <= acc_q[ACC_W-1 -: LUT_AW] + turn;
    end
endmodule

// File: rtl/nco_sine_lut.sv
// nco_sine_lut: quarter-wave sine table with mirror and sign logic.
// The table is computed at elaboration with half-step sample points, so
// the mirror index is the bitwise inverse. Registered output.
module nco_sine_lut #(
    parameter int LUT_AW = 10,
    parameter int AMP_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LUT_AW-1:0]       ph_addr,
    output logic signed [AMP_W-1:0] amp_q
);
    localparam int  IDX_W    = LUT_AW - 2;
    localparam int  QDEPTH   = 1 << IDX_W;
    localparam int  AMP_MAXI = (1 << (AMP_W - 1)) - 1;
    localparam real AMP_MAXR = real'(AMP_MAXI);

    logic [AMP_W-2:0] rom [QDEPTH];
    logic [IDX_W-1:0] idx;
    logic [AMP_W-2:0] mag;
    logic signed [AMP_W-1:0] amp_d;

    // Fill the table, one constant entry per generate step.
    for (genvar g = 0; g < QDEPTH; g++) begin : g_rom
        localparam int VAL = nco_pkg::quarter_amp(g, QDEPTH, AMP_MAXR);
        assign rom[g] = VAL[AMP_W-2:0];
    end

    // Mirror the index in odd quadrants, negate in the lower half wave.
    always_comb begin
        idx   = ph_addr[LUT_AW-2] ? ~ph_addr[IDX_W-1:0] : ph_addr[IDX_W-1:0];
        mag   = rom[idx];
        amp_d = ph_addr[LUT_AW-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

    // Register the signed amplitude.
    always_ff @(posedge clk) begin
        if (!rst_n) amp_q <= '0;
        else        amp_q <= amp_d;
    end
endmodule

// File: rtl/nco_out_round.sv
// nco_out_round: rounds the wide amplitude half-up to OUT_W bits, clips at
// positive full scale and applies the chosen output code. Registered.
module nco_out_round #(
    parameter int AMP_W          = 16,
    parameter int OUT_W          = 14,
    parameter bit OUT_OFFSET_BIN = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [AMP_W-1:0] amp_q,
    output logic [OUT_W-1:0]        sample
);
    localparam int SH = AMP_W - OUT_W;
    localparam logic signed [AMP_W:0] HALF = (AMP_W+1)'(1 << (SH - 1));
    localparam logic signed [OUT_W:0] MAXP = (OUT_W+1)'((1 << (OUT_W - 1)) - 1);
    localparam logic [OUT_W-1:0] ZERO_CODE =
        OUT_OFFSET_BIN ? {1'b1, {(OUT_W-1){1'b0}}} : '0;

    logic signed [AMP_W:0] sum;
    logic signed [OUT_W:0] shifted;
    logic [OUT_W-1:0]      res;
    logic [OUT_W-1:0]      coded;
    logic                  unused_frac;

    // Add the half-LSB and drop the fraction bits.
    always_comb begin
        sum         = {amp_q[AMP_W-1], amp_q} + HALF;
        shifted     = sum[AMP_W:SH];
        unused_frac = ^sum[SH-1:0];
        res         = (shifted > MAXP) ? MAXP[OUT_W-1:0] : shifted[OUT_W-1:0];
    end

    // Select the output code variant.
    if (OUT_OFFSET_BIN) begin : g_offbin
        assign coded = {~res[OUT_W-1], res[OUT_W-2:0]};
    end else begin : g_twos
        assign coded = res;
    end

    // Register the final sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sample <= ZERO_CODE;
        else        sample <= coded;
    end
endmodule

// File: rtl/nco_mod_core.sv
// nco_mod_core: top of the modulated NCO.
// Pipeline: phase register -> rotated address -> table amplitude -> sample.
// Phase pins reach the output in 3 edges, frequency controls in 4.
// Assumes tuning words are held stable by the surrounding register block.
module nco_mod_core #(
    parameter int ACC_W          = 48,
    parameter int SER_W          = 40,
    parameter int LUT_AW         = 10,
    parameter int AMP_W          = 16,
    parameter int OUT_W          = 14,
    parameter bit OUT_OFFSET_BIN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] center_word,
    input  logic [ACC_W-1:0] offset_word,
    input  logic [SER_W-1:0] serial_word,
    input  logic             offset_en,
    input  logic             serial_en,
    input  logic             fb_en,
    input  logic [1:0]       phase_sel,
    output logic [OUT_W-1:0] sample
);
    logic [ACC_W-1:0]        acc_q;
    logic [LUT_AW-1:0]       ph_addr;
    logic signed [AMP_W-1:0] amp_q;

    nco_phase_acc #(.ACC_W(ACC_W), .SER_W(SER_W)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .center_word(center_word), .offset_word(offset_word),
        .serial_word(serial_word), .offset_en(offset_en),
        .serial_en(serial_en), .fb_en(fb_en), .acc_q(acc_q)
    );

    nco_phase_map #(.ACC_W(ACC_W), .LUT_AW(LUT_AW)) u_map (
        .clk(clk), .rst_n(rst_n), .acc_q(acc_q),
        .phase_sel(phase_sel), .ph_addr(ph_addr)
    );

    nco_sine_lut #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_lut (
        .clk(clk), .rst_n(rst_n), .ph_addr(ph_addr), .amp_q(amp_q)
    );

    nco_out_round #(.AMP_W(AMP_W), .OUT_W(OUT_W), .OUT_OFFSET_BIN(OUT_OFFSET_BIN)) u_rnd (
        .clk(clk), .rst_n(rst_n), .amp_q(amp_q), .sample(sample)
    );
endmodule

// File: rtl/nco_mod_core_chk.sv
// nco_mod_core_chk: temporal checks on the NCO pipeline, bound to the top.
module nco_mod_core_chk #(
    parameter int ACC_W          = 48,
    parameter int SER_W          = 40,
    parameter int LUT_AW         = 10,
    parameter int AMP_W          = 16,
    parameter int OUT_W          = 14,
    parameter bit OUT_OFFSET_BIN = 1'b0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ACC_W-1:0]        center_word,
    input logic [ACC_W-1:0]        offset_word,
    input logic [SER_W-1:0]        serial_word,
    input logic                    offset_en,
    input logic                    serial_en,
    input logic                    fb_en,
    input logic [1:0]              phase_sel,
    input logic [ACC_W-1:0]        acc_q,
    input logic [LUT_AW-1:0]       ph_addr,
    input logic signed [AMP_W-1:0] amp_q,
    input logic [OUT_W-1:0]        sample
);
    localparam logic signed [AMP_W-1:0] AMP_TOP = (AMP_W)'((1 << (AMP_W - 1)) - 1);
    localparam logic [OUT_W-1:0] SAT_CODE =
        OUT_OFFSET_BIN ? {OUT_W{1'b1}} : {1'b0, {(OUT_W-1){1'b1}}};

    // R1: a low reset at an edge leaves the phase register cleared.
    a_r1_acc_cleared: assert property (@(posedge clk) !rst_n |=> (acc_q == '0));

    // R8: with feedback off twice and steady step inputs, the phase holds.
    a_r8_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb_en && $past(!fb_en) && $past(rst_n) && $stable(center_word) &&
         $stable(offset_word) && $stable(serial_word) && $stable(offset_en) &&
         $stable(serial_en)) |=> $stable(acc_q));

    // R10: a steady phase and steady phase pins give a steady address.
    a_r10_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(acc_q) && $stable(phase_sel)) |=> $stable(ph_addr));

    // R5: the upper half of the address gives a non-positive amplitude.
    a_r5_lower_half_sign: assert property (@(posedge clk) disable iff (!rst_n)
        ph_addr[LUT_AW-1] |=> (amp_q <= 0));

    // R5: the lower half of the address gives a positive amplitude.
    a_r5_upper_half_sign: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_addr[LUT_AW-1] |=> (amp_q > 0));

    // R7: the largest amplitude always leaves as the saturated code.
    a_r7_clip_top: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_q == AMP_TOP) |=> (sample == SAT_CODE));
endmodule

bind nco_mod_core nco_mod_core_chk #(
    .ACC_W(ACC_W), .SER_W(SER_W), .LUT_AW(LUT_AW),
    .AMP_W(AMP_W), .OUT_W(OUT_W), .OUT_OFFSET_BIN(OUT_OFFSET_BIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .center_word(center_word),
    .offset_word(offset_word), .serial_word(serial_word),
    .offset_en(offset_en), .serial_en(serial_en), .fb_en(fb_en),
    .phase_sel(phase_sel), .acc_q(acc_q), .ph_addr(ph_addr),
    .amp_q(amp_q), .sample(sample)
);

// File: tb/nco_mod_core_tb.sv
module nco_mod_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] center_word = '0;
    logic [47:0] offset_word = '0;
    logic [39:0] serial_word = '0;
    logic        offset_en = 1'b0;
    logic        serial_en = 1'b0;
    logic        fb_en = 1'b0;
    logic [1:0]  phase_sel = 2'd0;
    logic [13:0] sample;
    logic [13:0] sample_ob;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nco_mod_core u_dut (
        .clk(clk), .rst_n(rst_n), .center_word(center_word),
        .offset_word(offset_word), .serial_word(serial_word),
        .offset_en(offset_en), .serial_en(serial_en), .fb_en(fb_en),
        .phase_sel(phase_sel), .sample(sample)
    );

    nco_mod_core #(.OUT_OFFSET_BIN(1'b1)) u_dut_ob (
        .clk(clk), .rst_n(rst_n), .center_word(center_word),
        .offset_word(offset_word), .serial_word(serial_word),
        .offset_en(offset_en), .serial_en(serial_en), .fb_en(fb_en),
        .phase_sel(phase_sel), .sample(sample_ob)
    );

    localparam int NV = 10;
    localparam logic [47:0] V_CTR [NV] = '{
        48'(0), 48'(100) << 38, 48'(100) << 38, 48'(255) << 38, 48'(256) << 38,
        48'(768) << 38, 48'(300) << 38, 48'(900) << 38, 48'(512) << 38,
        (48'(7) << 38) | ((48'(1) << 38) - 48'(1))};
    localparam logic [47:0] V_OFS [NV] = '{
        48'(0), 48'(55) << 38, 48'(55) << 38, 48'(0), 48'(0),
        48'(0), 48'(0), 48'(200) << 38, 48'(0), 48'(1)};
    localparam logic V_OEN [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [1:0] V_PSEL [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 2'd3, 2'd1, 2'd0};

    function automatic string vec_tag(input int v);
        case (v)
            1: return "R2 offset added";
            2: return "R3 offset gated";
            3: return "R7 clip at top";
            4: return "R5 mirror quadrant";
            5: return "R7 negative extreme";
            6: return "R4 half turn";
            7: return "R4 three quarter turns with wrap";
            8: return "R4 quarter turn";
            9: return "R2 low-bit carry";
            default: return "R6 rounding";
        endcase
    endfunction

    function automatic int quarter(input int i);
        return $rtoi(32767.0 * $sin(3.141592653589793 * real'(2 * i + 1) / 1024.0) + 0.5);
    endfunction

    // Expected two's-complement sample for a 10-bit table address.
    function automatic logic [13:0] exp_addr(input logic [9:0] a);
        int i;
        int m;
        int s;
        int r;
        i = int'(a[7:0]);
        m = a[8] ? quarter(255 - i) : quarter(i);
        s = a[9] ? -m : m;
        r = (s + 2) >>> 2;
        if (r > 8191) r = 8191;
        return r[13:0];
    endfunction

    function automatic logic [13:0] exp_step(input logic [47:0] st, input logic [1:0] ps);
        logic [9:0] a;
        a = st[47:38] + {ps, 8'd0};
        return exp_addr(a);
    endfunction

    task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        step(3);
        check("R1 reset code", sample, 14'h0000);
        check("R13 reset code offset binary", sample_ob, 14'h2000);
        rst_n = 1'b1;

        // Vector walk with feedback off: the phase equals the step.
        for (int v = 0; v < NV; v++) begin
            logic [47:0] st;
            center_word = V_CTR[v];
            offset_word = V_OFS[v];
            offset_en   = V_OEN[v];
            phase_sel   = V_PSEL[v];
            step(6);
            st = V_CTR[v] + (V_OEN[v] ? V_OFS[v] : 48'd0);
            check(vec_tag(v), sample, exp_step(st, V_PSEL[v]));
            check("R13 offset binary", sample_ob, exp_step(st, V_PSEL[v]) ^ 14'h2000);
        end

        // R3: raising the offset enable again restores the held offset.
        center_word = 48'(100) << 38;
        offset_word = 48'(55) << 38;
        offset_en = 1'b0;
        phase_sel = 2'd0;
        step(6);
        offset_en = 1'b1;
        step(6);
        check("R3 offset restored", sample, exp_addr(10'd155));

        // R9: the auxiliary word adds at the LSB end only when enabled.
        center_word = 48'(10) << 38;
        offset_en = 1'b0;
        serial_word = 40'(3) << 38;
        serial_en = 1'b1;
        step(6);
        check("R9 serial added", sample, exp_addr(10'd13));
        serial_en = 1'b0;
        step(6);
        check("R9 serial ignored", sample, exp_addr(10'd10));
        serial_en = 1'b1;
        step(6);
        check("R9 serial restored", sample, exp_addr(10'd13));
        serial_en = 1'b0;

        // R10: a phase pin change reaches the output on the third edge.
        center_word = '0;
        phase_sel = 2'd0;
        step(8);
        phase_sel = 2'd1;
        step(2);
        check("R10 not before third edge", sample, exp_addr(10'd0));
        step(1);
        check("R10 on third edge", sample, exp_addr(10'd256));

        // R11: the offset enable reaches the output on the fourth edge.
        phase_sel = 2'd0;
        offset_word = 48'(255) << 38;
        offset_en = 1'b0;
        step(8);
        offset_en = 1'b1;
        step(3);
        check("R11 not before fourth edge", sample, exp_addr(10'd0));
        step(1);
        check("R11 on fourth edge", sample, exp_addr(10'd255));

        // R8 and R12: accumulate one address step per clock through a wrap.
        rst_n = 1'b0;
        center_word = 48'(1) << 38;
        offset_en = 1'b0;
        fb_en = 1'b1;
        step(2);
        rst_n = 1'b1;
        for (int e = 1; e <= 1030; e++) begin
            step(1);
            if (e >= 3) begin
                logic [9:0] a;
                a = 10'((e - 3) % 1024);
                if (e - 3 >= 1024) check("R12 wrap", sample, exp_addr(a));
                else               check("R8 accumulate", sample, exp_addr(a));
            end
        end

        // R8: feedback off freezes the phase at the step value.
        fb_en = 1'b0;
        step(6);
        check("R8 frozen", sample, exp_addr(10'd1));
        step(3);
        check("R8 still frozen", sample, exp_addr(10'd1));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule